// File: doc/BRIEF.md
# I2C Target Interface Controller

This block lets a host act as a target (slave) device on a two-wire I2C bus. It watches the open-drain SCL and SDA lines for a start condition followed by an address byte. It answers when that byte carries its programmed 7-bit address, or the general call address when that is enabled. Bytes move one at a time through a single data register. After every byte, or after an address match, the block holds SCL low until the host has serviced the data register and cleared the matching status flag, so no byte can be overrun or underrun.

Every bus event sets its own sticky status flag. The host clears a flag by writing a 0 to its position; positions written with 1 keep their value. An interrupt-enable register masks the status into a single interrupt line. The host reaches the block through a simple word-indexed register bus: index 0 control, 1 status, 2 interrupt enable, 3 own address (bits 6:0), 4 data (bits 7:0). Control bit 2 enables the target, bit 1 enables general call, and bit 0 forces NACK. Status bit 6 means general call received, 5 transmit direction, 4 stop seen, 3 data register empty, 2 byte transmitted, 1 byte received and 0 address matched. The interrupt-enable register uses the same layout.

Top module: `i2c_tgt`

## Requirements
- R1: After reset the control, status, interrupt-enable, own-address and data registers read 0, irq is low and neither SCL nor SDA is driven low.
- R2: An address byte whose upper 7 bits equal the own address, with R/W bit 0, is answered with ACK and sets status bit 0 with bit 5 cleared. Any other address is not acknowledged and leaves the status unchanged.
- R3: The address byte 0x00 is acknowledged only while control bit 1 is set, and it then sets status bits 6 and 0.
- R4: In the write direction, a received byte is acknowledged, placed in the data register and flagged in status bit 1.
- R5: While control bit 0 is set, a received data byte is answered with NACK. The data register keeps its previous value and status bit 1 is not set.
- R6: An own-address match with R/W bit 1 sets status bits 0 and 5. Once bit 0 is cleared, the data register content is shifted out MSB first and status bit 3 is set as the byte leaves the register. Status bit 2 is set when the controller's acknowledge bit is sampled.
- R7: SCL is held low after the address acknowledge until status bit 0 is cleared. It is also held low after a received byte until bit 1 is cleared, and after a transmitted byte that the controller acknowledged until bit 3 is cleared.
- R8: When the controller NACKs a transmitted byte, the block releases SDA and SCL and takes no further part until a stop or start.
- R9: A stop condition sets status bit 4 only if the block's address matched since the last start.
- R10: A status write clears each bit written as 0 and leaves each bit written as 1 unchanged.
- R11: irq is high exactly when some status bit is set whose interrupt-enable bit is also set.
- R12: With control bit 2 clear, the block ignores the bus: it acknowledges nothing and never holds SCL.
- R13: The block changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register word index |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Read data for the register at regAddr |
| sclIn | input | 1 | Sensed SCL line level |
| sdaIn | input | 1 | Sensed SDA line level |
| sclDriveLow | output | 1 | Pull SCL low (clock stretch) |
| sdaDriveLow | output | 1 | Pull SDA low |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: a two-stage line synchronizer, a three-bit register index and a 32-bit register bus. The bench drives SCL with 8-cycle half periods. With a two-cycle synchronizer the block sees each edge well inside one half period, so every bit phase of address, acknowledge, data and stop is reached with margin. The stretch windows are long enough that the bench can read the status and change registers while SCL is held. The bench bus model combines both sides open-drain, so a missing or misplaced ACK, or a stretch that never releases, shows at the line levels the controller model samples.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_W  = 8;
  localparam int ADDR7_W = 7;
  localparam int STAT_W  = 7;
  localparam int CTRL_W  = 3;

  // status / interrupt-enable bit positions
  localparam int ST_MATCH = 0;
  localparam int ST_RCVD  = 1;
  localparam int ST_SENT  = 2;
  localparam int ST_EMPTY = 3;
  localparam int ST_STOP  = 4;
  localparam int ST_TX    = 5;
  localparam int ST_GC    = 6;

  // control bit positions
  localparam int CT_FNACK = 0;
  localparam int CT_GCEN  = 1;
  localparam int CT_EN    = 2;

  // register word indices
  localparam int REG_CTRL   = 0;
  localparam int REG_STATUS = 1;
  localparam int REG_IE     = 2;
  localparam int REG_OWN    = 3;
  localparam int REG_DATA   = 4;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_ADDR_DEC, S_ACK_ADDR, S_HOLD_ADDR,
    S_RX, S_RX_DEC, S_RX_ACK, S_HOLD_RX,
    S_TX_LOAD, S_TX, S_TX_ACKCHK, S_TX_ACKEND, S_HOLD_TX, S_IGNORE
  } tgtState_e;

  typedef struct packed {
    logic shiftIn;
    logic shiftOut;
    logic loadTx;
    logic storeRx;
    logic setMatch;
    logic setGc;
    logic setDir;
    logic dirRead;
    logic setStop;
    logic setEmpty;
    logic setSent;
    logic setRcvd;
  } tgtStrobe_t;
endpackage

// File: rtl/i2c_tgt_dp.sv
module i2c_tgt_dp
  import i2c_tgt_pkg::*;
#(
  parameter int REG_AW = 3,
  parameter int BUS_W  = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [REG_AW-1:0]   regAddr,
  input  logic [BUS_W-1:0]    regWrData,
  output logic [BUS_W-1:0]    regRdData,
  input  tgtStrobe_t          stb,
  input  logic                sdaBit,
  output logic [BYTE_W-1:0]   shiftByte,
  output logic [CTRL_W-1:0]   ctrlBits,
  output logic [ADDR7_W-1:0]  ownAddr,
  output logic [STAT_W-1:0]   status,
  output logic                irq
);
  logic [STAT_W-1:0] intEn;
  logic [STAT_W-1:0] setMask;
  logic [STAT_W-1:0] statusN;
  logic [BYTE_W-1:0] dataReg;
  logic wrCtrl, wrStat, wrIe, wrOwn, wrData;
  logic unusedWrBits;

  assign unusedWrBits = ^regWrData[BUS_W-1:BYTE_W];

  assign wrCtrl = regWrEn && (regAddr == REG_AW'(REG_CTRL));
  assign wrStat = regWrEn && (regAddr == REG_AW'(REG_STATUS));
  assign wrIe   = regWrEn && (regAddr == REG_AW'(REG_IE));
  assign wrOwn  = regWrEn && (regAddr == REG_AW'(REG_OWN));
  assign wrData = regWrEn && (regAddr == REG_AW'(REG_DATA));

  always_comb begin
    setMask           = '0;
    setMask[ST_MATCH] = stb.setMatch;
    setMask[ST_GC]    = stb.setGc;
    setMask[ST_STOP]  = stb.setStop;
    setMask[ST_EMPTY] = stb.setEmpty;
    setMask[ST_SENT]  = stb.setSent;
    setMask[ST_RCVD]  = stb.setRcvd;
  end

  // host clears with zeros, bus events set (events win on a tie)
  always_comb begin
    statusN = status;
    if (wrStat) statusN = status & regWrData[STAT_W-1:0];
    statusN = statusN | setMask;
    if (stb.setDir) statusN[ST_TX] = stb.dirRead;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      status    <= '0;
      ctrlBits  <= '0;
      intEn     <= '0;
      ownAddr   <= '0;
      dataReg   <= '0;
      shiftByte <= '0;
    end else begin
      status <= statusN;
      if (wrCtrl) ctrlBits <= regWrData[CTRL_W-1:0];
      if (wrIe)   intEn    <= regWrData[STAT_W-1:0];
      if (wrOwn)  ownAddr  <= regWrData[ADDR7_W-1:0];
      if (stb.storeRx)  dataReg <= shiftByte;
      else if (wrData)  dataReg <= regWrData[BYTE_W-1:0];
      if (stb.loadTx)        shiftByte <= dataReg;
      else if (stb.shiftIn)  shiftByte <= {shiftByte[BYTE_W-2:0], sdaBit};
      else if (stb.shiftOut) shiftByte <= {shiftByte[BYTE_W-2:0], 1'b0};
    end
  end

  assign irq = |(status & intEn);

  always_comb begin
    regRdData = '0;
    case (regAddr)
      REG_AW'(REG_CTRL):   regRdData[CTRL_W-1:0]  = ctrlBits;
      REG_AW'(REG_STATUS): regRdData[STAT_W-1:0]  = status;
      REG_AW'(REG_IE):     regRdData[STAT_W-1:0]  = intEn;
      REG_AW'(REG_OWN):    regRdData[ADDR7_W-1:0] = ownAddr;
      REG_AW'(REG_DATA):   regRdData[BYTE_W-1:0]  = dataReg;
      default:             regRdData = '0;
    endcase
  end

  // R10: a host write with no concurrent event leaves status = old AND written
  a_r10_write_zero_clears: assert property (@(posedge clk) disable iff (!rstN)
    (wrStat && setMask == '0 && !stb.setDir) |=>
      status == ($past(status) & $past(regWrData[STAT_W-1:0])));

  // R9: the stop flag only rises on a strobe from the bus control
  a_r9_stop_from_bus: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status[ST_STOP]) |-> $past(stb.setStop));
endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
  import i2c_tgt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclIn,
  input  logic               sdaIn,
  input  logic [CTRL_W-1:0]  ctrlBits,
  input  logic [ADDR7_W-1:0] ownAddr,
  input  logic [STAT_W-1:0]  status,
  input  logic [BYTE_W-1:0]  shiftByte,
  output tgtStrobe_t         stb,
  output logic               sdaBit,
  output logic               sclDriveLow,
  output logic               sdaDriveLow
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclS, sdaS, sclPrev, sdaPrev;
  logic sclRise, sclFall, startCond, stopCond;
  logic enable, gcEn, fnack, ownHit, gcHit, selected;
  tgtState_e state, stateN;
  logic [CNT_W-1:0] cnt, cntN;
  logic readDir, readDirN;
  logic unusedStat;

  assign unusedStat = ^{status[ST_GC], status[ST_TX], status[ST_STOP], status[ST_SENT]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclS      = sclSync[SYNC_STAGES-1];
  assign sdaS      = sdaSync[SYNC_STAGES-1];
  assign sdaBit    = sdaS;
  assign sclRise   = sclS && !sclPrev;
  assign sclFall   = !sclS && sclPrev;
  assign startCond = sclS && sclPrev && sdaPrev && !sdaS;
  assign stopCond  = sclS && sclPrev && !sdaPrev && sdaS;

  assign enable = ctrlBits[CT_EN];
  assign gcEn   = ctrlBits[CT_GCEN];
  assign fnack  = ctrlBits[CT_FNACK];
  assign ownHit = shiftByte[BYTE_W-1:1] == ownAddr;
  assign gcHit  = gcEn && (shiftByte == '0);
  assign selected = !(state inside {S_IDLE, S_ADDR, S_ADDR_DEC});

  always_comb begin
    stb      = '0;
    stateN   = state;
    cntN     = cnt;
    readDirN = readDir;
    case (state)
      S_ADDR: if (sclRise) begin
        stb.shiftIn = 1'b1;
        cntN = cnt + 1'b1;
        if (cnt == LAST_BIT) stateN = S_ADDR_DEC;
      end
      S_ADDR_DEC: if (sclFall) begin
        if (ownHit || gcHit) begin
          stateN       = S_ACK_ADDR;
          stb.setMatch = 1'b1;
          stb.setGc    = gcHit && !ownHit;
          stb.setDir   = 1'b1;
          stb.dirRead  = shiftByte[0];
          readDirN     = shiftByte[0];
        end else begin
          stateN = S_IDLE;
        end
      end
      S_ACK_ADDR: if (sclFall) stateN = S_HOLD_ADDR;
      S_HOLD_ADDR: if (!status[ST_MATCH]) begin
        cntN = '0;
        if (readDir) begin
          stateN       = S_TX_LOAD;
          stb.loadTx   = 1'b1;
          stb.setEmpty = 1'b1;
        end else begin
          stateN = S_RX;
        end
      end
      S_RX: if (sclRise) begin
        stb.shiftIn = 1'b1;
        cntN = cnt + 1'b1;
        if (cnt == LAST_BIT) stateN = S_RX_DEC;
      end
      S_RX_DEC: if (sclFall) begin
        if (fnack) begin
          stateN = S_IGNORE;
        end else begin
          stateN      = S_RX_ACK;
          stb.storeRx = 1'b1;
          stb.setRcvd = 1'b1;
        end
      end
      S_RX_ACK: if (sclFall) stateN = S_HOLD_RX;
      S_HOLD_RX: if (!status[ST_RCVD]) begin
        cntN   = '0;
        stateN = S_RX;
      end
      S_TX_LOAD: stateN = S_TX;
      S_TX: if (sclFall) begin
        stb.shiftOut = 1'b1;
        cntN = cnt + 1'b1;
        if (cnt == LAST_BIT) stateN = S_TX_ACKCHK;
      end
      S_TX_ACKCHK: if (sclRise) begin
        stb.setSent = 1'b1;
        stateN = sdaS ? S_IGNORE : S_TX_ACKEND;
      end
      S_TX_ACKEND: if (sclFall) stateN = S_HOLD_TX;
      S_HOLD_TX: if (!status[ST_EMPTY]) begin
        cntN         = '0;
        stateN       = S_TX_LOAD;
        stb.loadTx   = 1'b1;
        stb.setEmpty = 1'b1;
      end
      default: ;
    endcase
    if (startCond) begin
      stateN = S_ADDR;
      cntN   = '0;
    end
    if (stopCond) begin
      stateN      = S_IDLE;
      stb.setStop = selected;
    end
    if (!enable) begin
      stb    = '0;
      stateN = S_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      cnt     <= '0;
      readDir <= 1'b0;
    end else begin
      state   <= stateN;
      cnt     <= cntN;
      readDir <= readDirN;
    end
  end

  assign sclDriveLow = state inside {S_HOLD_ADDR, S_HOLD_RX, S_HOLD_TX, S_TX_LOAD};
  assign sdaDriveLow = (state inside {S_ACK_ADDR, S_RX_ACK}) ||
                       ((state inside {S_TX_LOAD, S_TX}) && !shiftByte[BYTE_W-1]);

  // R13: SDA drive only moves while the sensed SCL is low
  a_r13_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rstN || !enable)
    !$stable(sdaDriveLow) |-> !sclS);

  // R5: a forced-NACK decision leaves SDA released
  a_r5_forced_nack: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RX_DEC && sclFall && fnack && enable && !startCond && !stopCond) |=>
      (!sdaDriveLow && state == S_IGNORE));

  // R7: received byte pending in the data register keeps SCL held
  a_r7_hold_rx: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_HOLD_RX && status[ST_RCVD] && enable && !startCond && !stopCond) |=>
      sclDriveLow);
endmodule

// File: rtl/i2c_tgt.sv
module i2c_tgt
  import i2c_tgt_pkg::*;
#(
  parameter int REG_AW      = 3,
  parameter int BUS_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [BUS_W-1:0]  regWrData,
  output logic [BUS_W-1:0]  regRdData,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sclDriveLow,
  output logic              sdaDriveLow,
  output logic              irq
);
  tgtStrobe_t          stb;
  logic                sdaBit;
  logic [BYTE_W-1:0]   shiftByte;
  logic [CTRL_W-1:0]   ctrlBits;
  logic [ADDR7_W-1:0]  ownAddr;
  logic [STAT_W-1:0]   status;

  i2c_tgt_ctrl #(.SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .ctrlBits(ctrlBits), .ownAddr(ownAddr), .status(status),
    .shiftByte(shiftByte), .stb(stb), .sdaBit(sdaBit),
    .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow)
  );

  i2c_tgt_dp #(.REG_AW(REG_AW), .BUS_W(BUS_W)) i_dp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .stb(stb),
    .sdaBit(sdaBit), .shiftByte(shiftByte), .ctrlBits(ctrlBits),
    .ownAddr(ownAddr), .status(status), .irq(irq)
  );
endmodule

// File: tb/test_i2c_tgt.sv
module test_i2c_tgt;
  localparam int H = 8;
  localparam int NVEC = 6;
  // {addr7, dataByte, forceNack, expAddrAck, expDataAck}
  localparam logic [17:0] VEC [NVEC] = '{
    {7'h3A, 8'hA5, 1'b0, 1'b1, 1'b1},
    {7'h3A, 8'h5A, 1'b1, 1'b1, 1'b0},
    {7'h3B, 8'h11, 1'b0, 1'b0, 1'b0},
    {7'h00, 8'hC3, 1'b0, 1'b1, 1'b1},
    {7'h7F, 8'h00, 1'b0, 1'b0, 1'b0},
    {7'h3A, 8'h0F, 1'b0, 1'b1, 1'b1}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [2:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic sclDriveLow, sdaDriveLow, irq;
  logic mScl = 1'b1;
  logic mSda = 1'b1;
  logic sclLine, sdaLine;
  int checks = 0;
  int errors = 0;
  logic [7:0] expData = 8'h00;

  assign sclLine = mScl & ~sclDriveLow;
  assign sdaLine = mSda & ~sdaDriveLow;

  always #2 clk = ~clk;

  i2c_tgt i_i2c_tgt (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .sclIn(sclLine),
    .sdaIn(sdaLine), .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow),
    .irq(irq)
  );

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hostWr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic hostRd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic mStart();
    mSda = 1'b1; mScl = 1'b1; wt(H);
    mSda = 1'b0; wt(H);
    mScl = 1'b0; wt(H);
  endtask

  task automatic mStop();
    mSda = 1'b0; wt(H);
    mScl = 1'b1; wt(H);
    mSda = 1'b1; wt(H);
  endtask

  task automatic mBit(input logic b, output logic r);
    mSda = b; wt(H);
    mScl = 1'b1;
    while (!sclLine) wt(1);
    wt(H/2);
    r = sdaLine;
    wt(H/2);
    mScl = 1'b0;
    wt(2);
  endtask

  task automatic mByteW(input logic [7:0] v, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) mBit(v[i], r);
    mBit(1'b1, r);
    ack = !r;
  endtask

  task automatic mByteR(input logic masterAck, output logic [7:0] v);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      mBit(1'b1, r);
      v[i] = r;
    end
    mBit(!masterAck, r);
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    wt(150000);
    errors++;
    $display("FAIL watchdog: actual still running, expected done");
    finishRun();
  end

  initial begin
    logic [31:0] d;
    logic ack, ack2;
    logic [7:0] rb;
    wt(3);
    rstN = 1'b1;
    wt(2);
    // R1 reset state
    hostRd(3'd1, d); check("R1 status", d, 32'h0);
    hostRd(3'd0, d); check("R1 ctrl", d, 32'h0);
    hostRd(3'd4, d); check("R1 data", d, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 line drive", {30'b0, sclDriveLow, sdaDriveLow}, 32'h0);

    hostWr(3'd3, 32'h3A);

    // vector table: write transactions
    for (int i = 0; i < NVEC; i++) begin
      logic [6:0] va;
      logic [7:0] vd;
      logic vf, vea, ved;
      {va, vd, vf, vea, ved} = VEC[i];
      hostWr(3'd0, {29'b0, 1'b1, 1'b1, vf});
      mStart();
      mByteW({va, 1'b0}, ack);
      check((va == 7'h00) ? "R3 gc ack" : "R2 addr ack", {31'b0, ack}, {31'b0, vea});
      if (vea) begin
        wt(4);
        check("R7 hold after addr", {31'b0, sclDriveLow}, 32'h1);
        hostRd(3'd1, d);
        check((va == 7'h00) ? "R3 gc status" : "R2 match status", d,
              (va == 7'h00) ? 32'h41 : 32'h01);
        hostWr(3'd1, 32'h3E);
        mByteW(vd, ack2);
        check(vf ? "R5 forced nack" : "R4 data ack", {31'b0, ack2}, {31'b0, ved});
        wt(4);
        if (ved) begin
          expData = vd;
          hostRd(3'd4, d); check("R4 data reg", d, {24'b0, vd});
          hostRd(3'd1, d); check("R4 rcvd flag", d, 32'h02);
          check("R7 hold after rx", {31'b0, sclDriveLow}, 32'h1);
          hostWr(3'd1, 32'h7D);
        end else begin
          hostRd(3'd4, d); check("R5 data kept", d, {24'b0, expData});
          hostRd(3'd1, d); check("R5 no rcvd flag", d, 32'h0);
        end
        mStop();
        wt(4);
        hostRd(3'd1, d); check("R9 stop flag", d, 32'h10);
        hostWr(3'd1, 32'h0);
      end else begin
        mStop();
        wt(4);
        hostRd(3'd1, d); check("R2 no match no status R9", d, 32'h0);
      end
    end

    // R6 / R7 / R8 read transfer
    hostWr(3'd0, 32'h4);
    hostWr(3'd4, 32'hC6);
    mStart();
    mByteW({7'h3A, 1'b1}, ack);
    check("R6 read addr ack", {31'b0, ack}, 32'h1);
    wt(4);
    hostRd(3'd1, d); check("R6 tx match status", d, 32'h21);
    check("R7 hold before first tx", {31'b0, sclDriveLow}, 32'h1);
    hostWr(3'd1, 32'h7E);
    wt(2);
    hostRd(3'd1, d); check("R6 empty after load", d, 32'h28);
    mByteR(1'b1, rb);
    check("R6 first byte", {24'b0, rb}, 32'hC6);
    wt(4);
    hostRd(3'd1, d); check("R6 sent flag", d, 32'h2C);
    check("R7 hold after acked tx", {31'b0, sclDriveLow}, 32'h1);
    hostWr(3'd4, 32'h3B);
    hostWr(3'd1, 32'h73);
    mByteR(1'b0, rb);
    check("R6 second byte", {24'b0, rb}, 32'h3B);
    wt(4);
    hostRd(3'd1, d); check("R8 sent after nack", d, 32'h2C);
    check("R8 lines released", {30'b0, sclDriveLow, sdaDriveLow}, 32'h0);
    mStop();
    wt(4);
    hostRd(3'd1, d); check("R9 stop after read", d, 32'h3C);

    // R10 / R11 status clear and interrupt mask
    hostWr(3'd1, 32'h7F);
    hostRd(3'd1, d); check("R10 ones keep", d, 32'h3C);
    hostWr(3'd2, 32'h01);
    check("R11 irq masked", {31'b0, irq}, 32'h0);
    hostWr(3'd2, 32'h10);
    check("R11 irq on stop", {31'b0, irq}, 32'h1);
    hostWr(3'd1, 32'h6F);
    hostRd(3'd1, d); check("R10 zero clears", d, 32'h2C);
    check("R11 irq after clear", {31'b0, irq}, 32'h0);
    hostWr(3'd1, 32'h0);
    hostWr(3'd2, 32'h0);

    // R3 general call refused when disabled
    hostWr(3'd0, 32'h4);
    mStart();
    mByteW(8'h00, ack);
    check("R3 gc disabled", {31'b0, ack}, 32'h0);
    mStop();
    wt(4);
    hostRd(3'd1, d); check("R3 gc disabled status", d, 32'h0);

    // R12 block disabled
    hostWr(3'd0, 32'h0);
    mStart();
    mByteW({7'h3A, 1'b0}, ack);
    check("R12 disabled no ack", {31'b0, ack}, 32'h0);
    check("R12 disabled no stretch", {31'b0, sclDriveLow}, 32'h0);
    mStop();
    wt(4);
    hostRd(3'd1, d); check("R12 disabled status", d, 32'h0);

    finishRun();
  end
endmodule